// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Tracker

This block keeps the tree pseudo-LRU replacement state for every set of a set-associative cache. Each set's tree is held in a small set-indexed memory with asynchronous reads. One shared combinational path serves the whole memory: it picks a victim way from a stored tree and computes the new tree after an access. Per-set logic is never replicated.

The cache presents each tag-match result on the lookup port: a valid flag, the set index, a hit flag and, for a hit, the way that matched. The block registers this lookup. In the following cycle it reads the set's tree. If the registered lookup was a hit, the updated tree is written back at the end of that cycle. If it was a miss and the miss handler raises `miss_start` in that cycle, the victim way is captured and announced with a one-cycle `victim_valid` strobe.

After reset the block clears every tree to zero, one set per cycle. It holds `busy` high while it does so and ignores all traffic until the clear is finished.

Top module: `plru_keeper`

## Requirements
- R1: When reset is released, `busy` is high. It falls after exactly SETS rising clock edges, and it never rises again until the next reset. After reset, `victim_valid` is 0 and `victim_way` is 0.
- R2: While `busy` is high, lookups and `miss_start` are ignored. Such traffic produces no `victim_valid` and changes no stored tree.
- R3: A set's tree has 2^WAY_BITS-1 node bits. Node 0 is the root. From node n, a 0 bit leads to node 2n+1 and a 1 bit leads to node 2n+2. The victim is found by walking from the root. Each visited node bit becomes the next victim-index bit, most significant bit first, and also selects the next node. A set whose tree is all zeros yields victim way 0.
- R4: A hit on way w walks the path that w's index bits select, most significant bit first. It sets each node on that path to the inverse of that level's bit and leaves every other node unchanged.
- R5: A miss lookup is registered at clock edge E1. If `miss_start` is high in the cycle after E1, the victim is captured at edge E2. `victim_valid` is then high for exactly the one cycle after E2.
- R6: `victim_way` holds its value until the next capture.
- R7: A miss lookup leaves the tree unchanged. A miss without `miss_start` in the following cycle captures nothing. A hit raises no `victim_valid`.
- R8: A hit lookup followed in the very next cycle by a lookup of the same set sees the tree that the hit wrote.
- R9: Each set's tree is independent. An access to one set never changes the victim chosen for another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A tag-match result is presented this cycle |
| lookup_set | input | SET_BITS | Set index of the lookup |
| lookup_hit | input | 1 | The lookup hit |
| lookup_way | input | WAY_BITS | Way that hit (ignored on a miss) |
| miss_start | input | 1 | Miss handling starts for the registered miss |
| busy | output | 1 | Reset clearing in progress; traffic ignored |
| victim_valid | output | 1 | One-cycle strobe: `victim_way` was just captured |
| victim_way | output | WAY_BITS | Way to replace, held until the next capture |

## Verification
A lookup driven before edge E1 is registered at E1. Its victim or tree write-back takes effect at E2, so `victim_valid` and `victim_way` are sampled on the falling edge after E2, and the strobe is checked low again one cycle later. Every stimulus is driven and every output is read on falling edges, so each check lands exactly in the cycle where its result is due. The bench reads tree contents back only through later misses. It compares each captured victim against a behavioural per-set tree model that is built from level offsets rather than a child walk. The `busy` fall is counted edge by edge from reset release.

// File: rtl/plru_keeper.sv
module plru_keeper #(
  parameter int SET_BITS = 4,
  parameter int WAY_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lookup_valid,
  input  logic [SET_BITS-1:0] lookup_set,
  input  logic                lookup_hit,
  input  logic [WAY_BITS-1:0] lookup_way,
  input  logic                miss_start,
  output logic                busy,
  output logic                victim_valid,
  output logic [WAY_BITS-1:0] victim_way
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int NODES = (1 << WAY_BITS) - 1;

  function automatic logic [WAY_BITS-1:0] pick(input logic [NODES-1:0] t);
    int n = 0;
    logic b;
    pick = '0;
    for (int i = 0; i < WAY_BITS; i++) begin
      b = (t[n] === 1'b1);
      pick[WAY_BITS-1-i] = b;
      n = 2*n + (b ? 2 : 1);
    end
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_BITS-1:0] w);
    int n = 0;
    logic b;
    touch = t;
    for (int i = 0; i < WAY_BITS; i++) begin
      b = (w[WAY_BITS-1-i] === 1'b1);
      touch[n] = ~b;
      n = 2*n + (b ? 2 : 1);
    end
  endfunction

  logic [NODES-1:0]    tree_mem [SETS];
  logic [SET_BITS-1:0] clr_idx;
  logic                s2_valid, s2_hit;
  logic [SET_BITS-1:0] s2_set;
  logic [WAY_BITS-1:0] s2_way;
  logic [NODES-1:0]    cur_tree;

  assign cur_tree = tree_mem[s2_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b1;
      clr_idx <= '0;
    end else if (busy) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == SET_BITS'(SETS-1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_hit   <= 1'b0;
      s2_set   <= '0;
      s2_way   <= '0;
    end else begin
      s2_valid <= lookup_valid && !busy;
      s2_hit   <= lookup_hit;
      s2_set   <= lookup_set;
      s2_way   <= lookup_way;
    end
  end

  always_ff @(posedge clk) begin
    if (busy) tree_mem[clr_idx] <= '0;
    else if (s2_valid && s2_hit) tree_mem[s2_set] <= touch(cur_tree, s2_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= 1'b0;
      if (!busy && s2_valid && !s2_hit && miss_start) begin
        victim_valid <= 1'b1;
        victim_way   <= pick(cur_tree);
      end
    end
  end
endmodule

// File: rtl/plru_keeper_checks.sv
module plru_keeper_checks #(
  parameter int SET_BITS = 4,
  parameter int WAY_BITS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lookup_valid,
  input logic                lookup_hit,
  input logic                miss_start,
  input logic                busy,
  input logic                victim_valid,
  input logic [WAY_BITS-1:0] victim_way
);
  a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  a_r2_no_capture_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !victim_valid);

  a_r5_strobe_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_start |=> !victim_valid);

  a_r6_victim_held: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_start |=> $stable(victim_way));

  a_r7_hit_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_hit && !busy) |=> ##1 !victim_valid);
endmodule

bind plru_keeper plru_keeper_checks #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) u_checks (
  .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_hit(lookup_hit),
  .miss_start(miss_start), .busy(busy), .victim_valid(victim_valid),
  .victim_way(victim_way)
);

// File: tb/plru_keeper_bench.sv
module plru_keeper_bench;
  localparam int SB = 3;
  localparam int WB = 3;
  localparam int SETS = 1 << SB;
  localparam int NODES = (1 << WB) - 1;

  logic clk = 0, rst_n = 0;
  logic lookup_valid = 0, lookup_hit = 0, miss_start = 0;
  logic [SB-1:0] lookup_set = '0;
  logic [WB-1:0] lookup_way = '0;
  logic busy, victim_valid;
  logic [WB-1:0] victim_way;

  int checks = 0, fails = 0;
  logic [NODES-1:0] model [SETS];

  always #4 clk = ~clk;

  plru_keeper #(.SET_BITS(SB), .WAY_BITS(WB)) u_plru_keeper (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_set(lookup_set),
    .lookup_hit(lookup_hit), .lookup_way(lookup_way), .miss_start(miss_start),
    .busy(busy), .victim_valid(victim_valid), .victim_way(victim_way)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m_victim(input logic [NODES-1:0] t);
    int p = 0;
    for (int i = 0; i < WB; i++) p = 2*p + int'(t[(1 << i) - 1 + p]);
    return p;
  endfunction

  function automatic logic [NODES-1:0] m_touch(input logic [NODES-1:0] t, input int w);
    logic [NODES-1:0] r = t;
    for (int i = 0; i < WB; i++) r[(1 << i) - 1 + (w >> (WB - i))] = ~w[WB-1-i];
    return r;
  endfunction

  // one lookup, optional miss_start in the next cycle; returns after E2
  task automatic access(input int s, input bit hit, input int w, input bit ms);
    lookup_valid = 1; lookup_set = SB'(s); lookup_hit = hit; lookup_way = WB'(w);
    @(negedge clk);
    lookup_valid = 0;
    miss_start = ms;
    @(negedge clk);
    miss_start = 0;
    if (hit) model[s] = m_touch(model[s], w);
  endtask

  task automatic miss_check(input int s, input string req);
    int exp;
    exp = m_victim(model[s]);
    access(s, 0, 0, 1);
    chk(victim_valid === 1'b1, req, int'(victim_valid), 1);
    chk(int'(victim_way) == exp, req, int'(victim_way), exp);
  endtask

  task automatic t_reset;
    int edges = 0;
    for (int i = 0; i < SETS; i++) model[i] = '0;
    chk(busy === 1'b1 && victim_valid === 1'b0 && victim_way === '0, "R1", int'(busy), 1);
    @(negedge clk) rst_n = 1;
    // R2: traffic during busy is ignored
    lookup_valid = 1; lookup_set = 0; lookup_hit = 1; lookup_way = 3'd5;
    miss_start = 1;
    while (busy === 1'b1 && edges < 100) begin
      @(negedge clk);
      edges++;
      chk(victim_valid === 1'b0, "R2", int'(victim_valid), 0);
    end
    lookup_valid = 0; miss_start = 0;
    chk(edges == SETS, "R1", edges, SETS);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", int'(busy), 0);
    miss_check(0, "R2");
  endtask

  task automatic t_walk;
    miss_check(1, "R3");
    access(1, 1, 0, 0);
    miss_check(1, "R4");
    chk(victim_way == 3'd4, "R4", int'(victim_way), 4);
    access(1, 1, 4, 0);
    miss_check(1, "R4");
    chk(victim_way == 3'd2, "R4", int'(victim_way), 2);
  endtask

  task automatic t_strobe;
    logic [WB-1:0] held;
    miss_check(2, "R5");
    held = victim_way;
    @(negedge clk);
    chk(victim_valid === 1'b0, "R5", int'(victim_valid), 0);
    access(3, 1, 6, 0);
    chk(victim_valid === 1'b0, "R7", int'(victim_valid), 0);
    access(3, 0, 0, 0);
    chk(victim_valid === 1'b0, "R7", int'(victim_valid), 0);
    chk(victim_way == held, "R6", int'(victim_way), int'(held));
    miss_check(3, "R7");
  endtask

  task automatic t_forward;
    int exp;
    lookup_valid = 1; lookup_set = 5; lookup_hit = 1; lookup_way = 3'd3;
    @(negedge clk);
    lookup_hit = 0; lookup_way = 0;
    model[5] = m_touch(model[5], 3);
    exp = m_victim(model[5]);
    @(negedge clk);
    lookup_valid = 0;
    miss_start = 1;
    @(negedge clk);
    miss_start = 0;
    chk(victim_valid === 1'b1, "R8", int'(victim_valid), 1);
    chk(int'(victim_way) == exp, "R8", int'(victim_way), exp);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      int s = $urandom_range(SETS - 1);
      int r = $urandom_range(9);
      if (r < 6) access(s, 1, $urandom_range((1 << WB) - 1), 0);
      else if (r == 6) access(s, 0, 0, 0);
      else miss_check(s, "R9");
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_walk();
    t_strobe();
    t_forward();
    t_random();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule